// File: doc/BRIEF.md
# Tape Pattern Run Detector

This block sits behind the pattern decoders of a multi-density tape read channel. It watches three one-bit pattern indicators: noise, all-ones block, and tape mark. For each one it raises a sticky status flag once that indicator has stayed asserted, with no gap, for a required number of bit cells. The required run length depends on the recording density (6250 or 1600 BPI) and on whether the channel reads back during a write or performs a plain read. At the lowest density every flag is held off.

Runs are measured on a half-cell tick supplied by the clock recovery logic, so a threshold of 12.5 cells is exact (25 half-cell ticks). Each indicator has its own channel controller with three states. `RS_IDLE` has no run in progress and a zero count. `RS_RUN` is counting half-cell ticks. `RS_SEEN` means the threshold was reached and the flag is set. The transitions are named as follows:
- *start* goes from `RS_IDLE` to `RS_RUN` on the first qualifying tick.
- *break* goes from `RS_RUN` to `RS_IDLE` when the indicator drops or the density disables detection.
- *hit* goes to `RS_SEEN` when the tick that completes the threshold arrives.
- *release* goes from any state to `RS_IDLE` when the read-enable qualifier is low or the controller-clear input is high.

Top module: `tape_run_detect`

## Requirements
- R1: At density code 2'b10 (6250) the noise flag (`flags[0]`) sets after 92 consecutive half-cell ticks with `ind[0]` high when `wr_op`=1, and after 44 ticks when `wr_op`=0. At density code 2'b01 (1600) the counts are 46 (write) and 22 (read). The flag is visible in the clock cycle after the clock edge that sampled the final tick. One tick fewer leaves it clear.
- R2: The block flag (`flags[1]`, indicator `ind[1]`) sets after 50 consecutive half-cell ticks at 6250 and after 25 at 1600, for both values of `wr_op`.
- R3: The tape-mark flag (`flags[2]`, indicator `ind[2]`) sets after 608 ticks at 6250 write, 84 at 6250 read, 168 at 1600 write and 42 at 1600 read.
- R4: A set flag stays set while `rd_en` is high, even after its indicator drops. A clock edge that samples `rd_en` low clears every flag and counter, and they stay clear while `rd_en` is low.
- R5: With density code 2'b00 (800) or the unused code 2'b11, no flag can set, however long an indicator stays high.
- R6: A clock edge that samples an indicator low restarts that channel's run from zero. Ticks taken before the gap do not count toward the threshold.
- R7: Each run count saturates at its threshold and never wraps. A set flag stays set while its indicator remains high for many more ticks.
- R8: A clock edge that samples `ctl_clr` high clears all flags and counters. This holds even when the same edge samples the tick that would have completed a run.
- R9: The three channels are independent. Bit i of `ind` drives bit i of `flags` (0 noise, 1 block, 2 tape mark), and several flags can be set at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_clr | input | 1 | Synchronous clear of all flags and counters |
| rd_en | input | 1 | Read-enable qualifier; low clears and holds flags clear |
| dens | input | 2 | Density select: 00 800, 01 1600, 10 6250, 11 unused (off) |
| wr_op | input | 1 | 1 = read-after-write, 0 = plain read |
| half_tick | input | 1 | One-cycle pulse per half bit cell |
| ind | input | 3 | Pattern indicators: [0] noise, [1] block, [2] tape mark |
| flags | output | 3 | Sticky run flags, same bit order as `ind` |

## Verification
A run can complete in the same cycle that a clear arrives. In that case the *hit* and *release* transitions compete for one channel. The bench brings a noise run to one tick below its threshold, then presents the completing tick and `ctl_clr` together. It expects the flag to stay clear, and then expects a full new run (not a single extra tick) to be needed before the flag sets. A second overlap is provoked when all three indicators run together, so that two channels take *start* or *hit* on the same tick. Each flag is judged at its own threshold.

// File: rtl/tprd_pkg.sv
package tprd_pkg;

    localparam int NCH      = 3;
    localparam int CH_NOISE = 0;
    localparam int CH_BLOCK = 1;
    localparam int CH_TMARK = 2;

    typedef enum logic [1:0] {
        DENS_LOW  = 2'b00,
        DENS_1600 = 2'b01,
        DENS_6250 = 2'b10,
        DENS_RSV  = 2'b11
    } dens_e;

    typedef enum logic [1:0] {
        RS_IDLE = 2'b00,
        RS_RUN  = 2'b01,
        RS_SEEN = 2'b10
    } run_state_e;

endpackage

// File: rtl/tprd_thresh.sv
module tprd_thresh #(
    parameter int CNT_W   = 10,
    parameter int NS_62_W = 92,
    parameter int NS_62_R = 44,
    parameter int NS_16_W = 46,
    parameter int NS_16_R = 22,
    parameter int BK_62   = 50,
    parameter int BK_16   = 25,
    parameter int TM_62_W = 608,
    parameter int TM_62_R = 84,
    parameter int TM_16_W = 168,
    parameter int TM_16_R = 42
) (
    input  logic [1:0]                        dens,
    input  logic                              wr_op,
    output logic                              active,
    output logic [tprd_pkg::NCH*CNT_W-1:0]    thr_flat
);
    import tprd_pkg::*;

    logic [CNT_W-1:0] t_noise;
    logic [CNT_W-1:0] t_block;
    logic [CNT_W-1:0] t_tmark;

    always_comb begin
        active  = 1'b0;
        t_noise = '0;
        t_block = '0;
        t_tmark = '0;
        unique case (dens_e'(dens))
            DENS_6250: begin
                active  = 1'b1;
                t_noise = wr_op ? CNT_W'(NS_62_W) : CNT_W'(NS_62_R);
                t_block = CNT_W'(BK_62);
                t_tmark = wr_op ? CNT_W'(TM_62_W) : CNT_W'(TM_62_R);
            end
            DENS_1600: begin
                active  = 1'b1;
                t_noise = wr_op ? CNT_W'(NS_16_W) : CNT_W'(NS_16_R);
                t_block = CNT_W'(BK_16);
                t_tmark = wr_op ? CNT_W'(TM_16_W) : CNT_W'(TM_16_R);
            end
            DENS_LOW, DENS_RSV: begin
                active = 1'b0;
            end
            default: active = 1'b0;
        endcase
    end

    assign thr_flat[CH_NOISE*CNT_W +: CNT_W] = t_noise;
    assign thr_flat[CH_BLOCK*CNT_W +: CNT_W] = t_block;
    assign thr_flat[CH_TMARK*CNT_W +: CNT_W] = t_tmark;

endmodule

// File: rtl/tprd_run_fsm.sv
module tprd_run_fsm #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             active,
    input  logic             tick,
    input  logic             ind,
    input  logic [CNT_W-1:0] thr,
    output logic             flag,
    output logic [CNT_W-1:0] cnt
);
    import tprd_pkg::*;

    run_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // transitions: start, break, hit, release
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (clr || !en) begin
            state_nxt = RS_IDLE;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                RS_IDLE: begin
                    cnt_nxt = '0;
                    if (ind && active && tick) begin
                        if (thr <= CNT_W'(1)) begin
                            state_nxt = RS_SEEN;
                            cnt_nxt   = thr;
                        end else begin
                            state_nxt = RS_RUN;
                            cnt_nxt   = CNT_W'(1);
                        end
                    end
                end
                RS_RUN: begin
                    if (!ind || !active) begin
                        state_nxt = RS_IDLE;
                        cnt_nxt   = '0;
                    end else if (tick) begin
                        if (cnt_inc >= {1'b0, thr}) begin
                            state_nxt = RS_SEEN;
                            cnt_nxt   = thr;
                        end else begin
                            cnt_nxt = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                RS_SEEN: begin
                    state_nxt = RS_SEEN;
                end
                default: begin
                    state_nxt = RS_IDLE;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        flag = (state == RS_SEEN);
    end

endmodule

// File: rtl/tape_run_detect.sv
module tape_run_detect #(
    parameter int CNT_W   = 10,
    parameter int NS_62_W = 92,
    parameter int NS_62_R = 44,
    parameter int NS_16_W = 46,
    parameter int NS_16_R = 22,
    parameter int BK_62   = 50,
    parameter int BK_16   = 25,
    parameter int TM_62_W = 608,
    parameter int TM_62_R = 84,
    parameter int TM_16_W = 168,
    parameter int TM_16_R = 42
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_clr,
    input  logic       rd_en,
    input  logic [1:0] dens,
    input  logic       wr_op,
    input  logic       half_tick,
    input  logic [2:0] ind,
    output logic [2:0] flags
);
    import tprd_pkg::*;

    localparam int FLAT_W = NCH * CNT_W;

    logic              active;
    logic [FLAT_W-1:0] thr_flat;
    logic [FLAT_W-1:0] cnt_flat;

    tprd_thresh #(
        .CNT_W(CNT_W),
        .NS_62_W(NS_62_W), .NS_62_R(NS_62_R),
        .NS_16_W(NS_16_W), .NS_16_R(NS_16_R),
        .BK_62(BK_62),     .BK_16(BK_16),
        .TM_62_W(TM_62_W), .TM_62_R(TM_62_R),
        .TM_16_W(TM_16_W), .TM_16_R(TM_16_R)
    ) u_thresh (
        .dens     (dens),
        .wr_op    (wr_op),
        .active   (active),
        .thr_flat (thr_flat)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        tprd_run_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (ctl_clr),
            .en     (rd_en),
            .active (active),
            .tick   (half_tick),
            .ind    (ind[ch]),
            .thr    (thr_flat[ch*CNT_W +: CNT_W]),
            .flag   (flags[ch]),
            .cnt    (cnt_flat[ch*CNT_W +: CNT_W])
        );
    end

endmodule

// File: rtl/tprd_checker.sv
module tprd_checker #(
    parameter int CNT_W = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ctl_clr,
    input logic                   rd_en,
    input logic [1:0]             dens,
    input logic                   half_tick,
    input logic [2:0]             ind,
    input logic [2:0]             flags,
    input logic [3*CNT_W-1:0]     cnt_flat,
    input logic [3*CNT_W-1:0]     thr_flat
);

    // R4: qualifier low clears every flag at that edge
    p_hold_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (flags == 3'b000));

    // R4: set flags are kept while qualified and not cleared
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ctl_clr) |=> ((flags & $past(flags)) == $past(flags)));

    // R8: controller clear wipes flags and counts
    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clr |=> ((flags == 3'b000) && (cnt_flat == '0)));

    // R5: no new flag while density is 800 or unused
    p_no_set_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((dens == 2'b00) || (dens == 2'b11)) |=> ((flags & ~$past(flags)) == 3'b000));

    for (genvar ch = 0; ch < 3; ch++) begin : g_chk
        // R6: a flag only rises on a sampled tick with its indicator high
        p_need_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[ch]) |-> ($past(ind[ch]) && $past(half_tick)));

        // R7: a count that moves never passes the threshold
        p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt_flat[ch*CNT_W +: CNT_W] != $past(cnt_flat[ch*CNT_W +: CNT_W])) &&
             (cnt_flat[ch*CNT_W +: CNT_W] != '0))
            |-> (cnt_flat[ch*CNT_W +: CNT_W] <= thr_flat[ch*CNT_W +: CNT_W]));
    end

endmodule

bind tape_run_detect tprd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_clr   (ctl_clr),
    .rd_en     (rd_en),
    .dens      (dens),
    .half_tick (half_tick),
    .ind       (ind),
    .flags     (flags),
    .cnt_flat  (cnt_flat),
    .thr_flat  (thr_flat)
);

// File: tb/tape_run_detect_bench.sv
module tape_run_detect_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_clr = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] dens = 2'b00;
    logic       wr_op = 1'b0;
    logic       half_tick = 1'b0;
    logic [2:0] ind = 3'b000;
    logic [2:0] flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    tape_run_detect u_tape_run_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_clr   (ctl_clr),
        .rd_en     (rd_en),
        .dens      (dens),
        .wr_op     (wr_op),
        .half_tick (half_tick),
        .ind       (ind),
        .flags     (flags)
    );

    // monitor: compare queued expectations on falling edges
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (flags !== it.exp) begin
                    errors++;
                    $display("FAIL %s: flags=%b expected %b", it.tag, flags, it.exp);
                end
            end
        end
    end

    task automatic expect_flags(input logic [2:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic tick_run(input logic [2:0] ind_v, input int n);
        ind = ind_v;
        for (int i = 0; i < n; i++) begin
            half_tick = 1'b1;
            @(negedge clk);
            half_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic restart(input logic [1:0] d, input logic w);
        ind   = 3'b000;
        rd_en = 1'b0;
        @(negedge clk);
        dens  = d;
        wr_op = w;
        rd_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic thr_case(input logic [1:0] d, input logic w, input logic [2:0] iv,
                            input int n, input string tag);
        restart(d, w);
        tick_run(iv, n - 1);
        expect_flags(3'b000, {tag, " one short"});
        tick_run(iv, 1);
        expect_flags(iv, {tag, " at threshold"});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_flags(3'b000, "reset state");

        // R1 noise thresholds
        thr_case(2'b10, 1'b1, 3'b001, 92,  "R1 noise 6250 write");
        thr_case(2'b10, 1'b0, 3'b001, 44,  "R1 noise 6250 read");
        thr_case(2'b01, 1'b1, 3'b001, 46,  "R1 noise 1600 write");
        thr_case(2'b01, 1'b0, 3'b001, 22,  "R1 noise 1600 read");
        // R2 block thresholds
        thr_case(2'b10, 1'b1, 3'b010, 50,  "R2 block 6250 write");
        thr_case(2'b10, 1'b0, 3'b010, 50,  "R2 block 6250 read");
        thr_case(2'b01, 1'b1, 3'b010, 25,  "R2 block 1600 write");
        thr_case(2'b01, 1'b0, 3'b010, 25,  "R2 block 1600 read");
        // R3 tape-mark thresholds
        thr_case(2'b10, 1'b1, 3'b100, 608, "R3 tmark 6250 write");
        thr_case(2'b10, 1'b0, 3'b100, 84,  "R3 tmark 6250 read");
        thr_case(2'b01, 1'b1, 3'b100, 168, "R3 tmark 1600 write");
        thr_case(2'b01, 1'b0, 3'b100, 42,  "R3 tmark 1600 read");

        // R4 sticky after indicator drops, then cleared by qualifier
        tick_run(3'b000, 5);
        expect_flags(3'b100, "R4 sticky after indicator low");
        rd_en = 1'b0;
        @(negedge clk);
        expect_flags(3'b000, "R4 cleared while qualifier low");
        tick_run(3'b100, 50);
        expect_flags(3'b000, "R4 held clear while qualifier low");
        rd_en = 1'b1;

        // R6 a gap restarts the run
        restart(2'b10, 1'b0);
        tick_run(3'b001, 40);
        ind = 3'b000;
        @(negedge clk);
        tick_run(3'b001, 43);
        expect_flags(3'b000, "R6 broken run not counted");
        tick_run(3'b001, 1);
        expect_flags(3'b001, "R6 fresh run completes");

        // R8 clear colliding with the completing tick
        restart(2'b10, 1'b1);
        tick_run(3'b001, 91);
        half_tick = 1'b1;
        ctl_clr   = 1'b1;
        @(negedge clk);
        half_tick = 1'b0;
        ctl_clr   = 1'b0;
        expect_flags(3'b000, "R8 clear wins over hit");
        tick_run(3'b001, 1);
        expect_flags(3'b000, "R8 count restarted after clear");
        tick_run(3'b001, 91);
        expect_flags(3'b001, "R8 full run after clear");
        ctl_clr = 1'b1;
        @(negedge clk);
        ctl_clr = 1'b0;
        expect_flags(3'b000, "R8 clear of set flag");

        // R9 independent channels, overlapping runs
        restart(2'b10, 1'b0);
        tick_run(3'b111, 44);
        expect_flags(3'b001, "R9 noise first");
        tick_run(3'b111, 6);
        expect_flags(3'b011, "R9 block second");
        tick_run(3'b111, 34);
        expect_flags(3'b111, "R9 tmark third");
        // R7 long run past threshold keeps flags set
        tick_run(3'b111, 700);
        expect_flags(3'b111, "R7 saturated run keeps flags");

        // R5 low density and unused code
        restart(2'b00, 1'b1);
        tick_run(3'b111, 700);
        expect_flags(3'b000, "R5 800 mode no flag");
        restart(2'b11, 1'b0);
        tick_run(3'b111, 700);
        expect_flags(3'b000, "R5 unused density no flag");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule